// File: doc/BRIEF.md
# USB Endpoint Control Registers

This block keeps the per-endpoint control and handshake state of a USB device controller. For every endpoint it holds an enable flag, a sticky STALL request, the current data toggle and a FIFO reset request. Software reaches the state through a register port. A write names one of two registers and an endpoint number, and the selected register is always visible on a combinational read bus.

The USB core side drives three kinds of event. A SETUP arrival clears the STALL request of the endpoint that received it. A transfer-complete pulse inverts the toggle of an enabled endpoint. A bus reset returns every endpoint to its post-reset handshake state. The block presents stall, toggle, enable and FIFO reset as flat vectors with one bit per endpoint.

Some control bits are strobes that clear themselves and always read 0. Others are sticky bits that only hardware clears. A software write of 0 to a sticky bit does nothing. When set and clear requests meet in the same cycle, the clear side wins.

Top module: `usbEpRegs`

## Requirements
- R1: After hardware reset, endpoint 0 is enabled, all other endpoints are disabled, and every stall, toggle and FIFO reset bit is 0.
- R2: A write to the control register (address 0) sets the selected endpoint's enable to bit 0 of the write data. The control register reads back the enable in bit 0.
- R3: Writing 1 in control bit 1 sets the endpoint's sticky STALL request, which reads back in bit 1. A write with bit 1 at 0 leaves the request unchanged.
- R4: A SETUP event clears the STALL request of the endpoint it names and of no other endpoint. It wins over a software set in the same cycle.
- R5: Writing 1 in control bit 2 clears the STALL request and wins over bit 1 set in the same write. Bit 2 always reads 0.
- R6: A transfer event inverts the toggle of the named endpoint only if that endpoint is enabled. The toggle reads back in control bit 4, and writes to bit 4 are ignored.
- R7: Writing 1 in control bit 3 forces the toggle to 0 and wins over a transfer event in the same cycle. Bit 3 always reads 0.
- R8: A bus reset clears every STALL request and toggle, enables endpoint 0 and disables all others. It wins over same-cycle writes and leaves the FIFO reset bits unchanged.
- R9: Address 1 is the FIFO reset register. Bit e holds endpoint e's FIFO in reset while it is 1, and the bit is read/write.
- R10: Reserved bits (control bits 5 and up, FIFO bits at and above the endpoint count) read 0 and ignore writes. An endpoint select at or above the endpoint count changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control register, 1 = FIFO reset register |
| epSel | input | EPW | Endpoint selected for control access |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the selected register |
| setupRcvd | input | 1 | SETUP packet received |
| setupEp | input | EPW | Endpoint of the SETUP packet |
| xferDone | input | 1 | Data packet acknowledged |
| xferEp | input | EPW | Endpoint of the acknowledged packet |
| busReset | input | 1 | USB bus reset seen |
| enOut | output | NUM_EP | Endpoint enable per endpoint |
| stallOut | output | NUM_EP | STALL request active per endpoint |
| toggleOut | output | NUM_EP | Current data toggle per endpoint |
| fifoRstOut | output | NUM_EP | FIFO held in reset per endpoint |

## Verification
Directed sequences cover the priority collisions, where a set-only model and a clear-wins model give different results: set plus clear in one write, SETUP against a set, a toggle reset against a transfer while the toggle is 0, and a bus reset against an enable write. Transfers to a disabled endpoint and selects past the last endpoint separate a correct model from one that ignores gating or address range. Constrained random cycles then mix writes, events and rare bus resets. Every output and the read bus are compared with a bench model after each cycle, which exposes wrong priorities that the directed cases miss.

// File: rtl/usbEpPkg.sv
package usbEpPkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FIFO = 1'b1;

  localparam int EN_BIT       = 0;
  localparam int STALL_BIT    = 1;
  localparam int STALL_CLR_BIT = 2;
  localparam int TOG_RST_BIT  = 3;
  localparam int TOG_RD_BIT   = 4;

  typedef struct packed {
    logic enWr;
    logic enVal;
    logic stallSet;
    logic stallClr;
    logic togRst;
    logic togFlip;
    logic busRst;
    logic fifoWr;
    logic fifoVal;
  } epStrobe_t;
endpackage

// File: rtl/usbEpCtrl.sv
module usbEpCtrl
  import usbEpPkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int DW     = 8,
  parameter int EPW    = 3
) (
  input  logic                   regWe,
  input  logic                   regAddr,
  input  logic [EPW-1:0]         epSel,
  input  logic [DW-1:0]          wdata,
  input  logic                   setupRcvd,
  input  logic [EPW-1:0]         setupEp,
  input  logic                   xferDone,
  input  logic [EPW-1:0]         xferEp,
  input  logic                   busReset,
  output epStrobe_t [NUM_EP-1:0] strb
);
  logic ctrlWr;
  logic fifoWr;

  assign ctrlWr = regWe && (regAddr == ADDR_CTRL);
  assign fifoWr = regWe && (regAddr == ADDR_FIFO);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit;
    logic setupHit;
    assign hit      = ctrlWr && (epSel == EPW'(e));
    assign setupHit = setupRcvd && (setupEp == EPW'(e));

    always_comb begin
      strb[e].enWr     = hit;
      strb[e].enVal    = wdata[EN_BIT];
      strb[e].stallSet = hit && wdata[STALL_BIT];
      strb[e].stallClr = (hit && wdata[STALL_CLR_BIT]) || setupHit;
      strb[e].togRst   = hit && wdata[TOG_RST_BIT];
      strb[e].togFlip  = xferDone && (xferEp == EPW'(e));
      strb[e].busRst   = busReset;
      strb[e].fifoWr   = fifoWr;
      strb[e].fifoVal  = wdata[e];
    end
  end
endmodule

// File: rtl/usbEpData.sv
module usbEpData
  import usbEpPkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int DW     = 8,
  parameter int EPW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  epStrobe_t [NUM_EP-1:0] strb,
  input  logic                   regAddr,
  input  logic [EPW-1:0]         epSel,
  output logic [NUM_EP-1:0]      enOut,
  output logic [NUM_EP-1:0]      stallOut,
  output logic [NUM_EP-1:0]      toggleOut,
  output logic [NUM_EP-1:0]      fifoRstOut,
  output logic [DW-1:0]          rdata
);
  logic [NUM_EP-1:0] en, stall, tog, fifoRst;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    localparam logic EN_INIT = (e == 0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[e]      <= EN_INIT;
        stall[e]   <= 1'b0;
        tog[e]     <= 1'b0;
        fifoRst[e] <= 1'b0;
      end else begin
        if (strb[e].busRst) begin
          en[e]    <= EN_INIT;
          stall[e] <= 1'b0;
          tog[e]   <= 1'b0;
        end else begin
          if (strb[e].enWr) en[e] <= strb[e].enVal;
          if (strb[e].stallClr) stall[e] <= 1'b0;
          else if (strb[e].stallSet) stall[e] <= 1'b1;
          if (strb[e].togRst) tog[e] <= 1'b0;
          else if (strb[e].togFlip && en[e]) tog[e] <= ~tog[e];
        end
        if (strb[e].fifoWr) fifoRst[e] <= strb[e].fifoVal;
      end
    end

    // R7
    tog_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb[e].togRst |=> !tog[e]);

    // R3
    stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall[e]) |-> $past(strb[e].stallSet));

    // R9
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strb[e].fifoWr |=> $stable(fifoRst[e]));
  end

  always_comb begin
    rdata = '0;
    if (regAddr == ADDR_FIFO) begin
      rdata[NUM_EP-1:0] = fifoRst;
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (epSel == EPW'(e)) begin
          rdata[EN_BIT]     = en[e];
          rdata[STALL_BIT]  = stall[e];
          rdata[TOG_RD_BIT] = tog[e];
        end
      end
    end
  end

  assign enOut      = en;
  assign stallOut   = stall;
  assign toggleOut  = tog;
  assign fifoRstOut = fifoRst;

  // R8
  bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb[0].busRst |=> (en[0] && stall == '0 && tog == '0));
endmodule

// File: rtl/usbEpRegs.sv
module usbEpRegs
  import usbEpPkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int DW     = 8,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [EPW-1:0]    epSel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              setupRcvd,
  input  logic [EPW-1:0]    setupEp,
  input  logic              xferDone,
  input  logic [EPW-1:0]    xferEp,
  input  logic              busReset,
  output logic [NUM_EP-1:0] enOut,
  output logic [NUM_EP-1:0] stallOut,
  output logic [NUM_EP-1:0] toggleOut,
  output logic [NUM_EP-1:0] fifoRstOut
);
  epStrobe_t [NUM_EP-1:0] strb;

  usbEpCtrl #(.NUM_EP(NUM_EP), .DW(DW), .EPW(EPW)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .epSel(epSel), .wdata(wdata),
    .setupRcvd(setupRcvd), .setupEp(setupEp),
    .xferDone(xferDone), .xferEp(xferEp),
    .busReset(busReset), .strb(strb)
  );

  usbEpData #(.NUM_EP(NUM_EP), .DW(DW), .EPW(EPW)) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .regAddr(regAddr), .epSel(epSel),
    .enOut(enOut), .stallOut(stallOut), .toggleOut(toggleOut),
    .fifoRstOut(fifoRstOut), .rdata(rdata)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_chk
    // R4
    setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setupRcvd && setupEp == EPW'(e)) |=> !stallOut[e]);
  end
endmodule

// File: tb/usbEpRegs_test.sv
module usbEpRegs_test;
  localparam int N = 7;
  localparam int DW = 8;
  localparam int EPW = 3;

  logic clk = 0, rst_n = 0;
  logic regWe = 0, regAddr = 0;
  logic [EPW-1:0] epSel = 0, setupEp = 0, xferEp = 0;
  logic [DW-1:0] wdata = 0;
  logic setupRcvd = 0, xferDone = 0, busReset = 0;
  logic [DW-1:0] rdata;
  logic [N-1:0] enOut, stallOut, toggleOut, fifoRstOut;

  logic [N-1:0] mEn, mStall, mTog, mFifo;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  usbEpRegs #(.NUM_EP(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .epSel(epSel), .wdata(wdata), .rdata(rdata),
    .setupRcvd(setupRcvd), .setupEp(setupEp),
    .xferDone(xferDone), .xferEp(xferEp), .busReset(busReset),
    .enOut(enOut), .stallOut(stallOut), .toggleOut(toggleOut),
    .fifoRstOut(fifoRstOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expRead();
    logic [DW-1:0] r = '0;
    if (regAddr) r[N-1:0] = mFifo;
    else if (epSel < N) begin
      r[0] = mEn[epSel];
      r[1] = mStall[epSel];
      r[4] = mTog[epSel];
    end
    return r;
  endfunction

  task automatic modelStep();
    for (int e = 0; e < N; e++) begin
      logic hit;
      hit = regWe && !regAddr && (epSel == EPW'(e));
      if (busReset) begin
        mEn[e] = (e == 0);
        mStall[e] = 0;
        mTog[e] = 0;
      end else begin
        if (hit && wdata[3]) mTog[e] = 0;
        else if (xferDone && xferEp == EPW'(e) && mEn[e]) mTog[e] = ~mTog[e];
        if ((hit && wdata[2]) || (setupRcvd && setupEp == EPW'(e))) mStall[e] = 0;
        else if (hit && wdata[1]) mStall[e] = 1;
        if (hit) mEn[e] = wdata[0];
      end
      if (regWe && regAddr) mFifo[e] = wdata[e];
    end
  endtask

  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    regWe = 0; setupRcvd = 0; xferDone = 0; busReset = 0;
  endtask

  task automatic checkAll();
    chk("R2 enOut", enOut, mEn);
    chk("R3 stallOut", stallOut, mStall);
    chk("R6 toggleOut", toggleOut, mTog);
    chk("R9 fifoRstOut", fifoRstOut, mFifo);
    chk("R10 rdata", rdata, expRead());
  endtask

  task automatic wr(logic a, logic [EPW-1:0] s, logic [DW-1:0] d);
    regWe = 1; regAddr = a; epSel = s; wdata = d;
    step();
  endtask

  task automatic xfer(logic [EPW-1:0] s);
    xferDone = 1; xferEp = s;
    step();
  endtask

  task automatic setup(logic [EPW-1:0] s);
    setupRcvd = 1; setupEp = s;
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    mEn = 7'h01; mStall = 0; mTog = 0; mFifo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enOut", enOut, 7'h01);
    chk("R1 stallOut", stallOut, 0);
    chk("R1 toggleOut", toggleOut, 0);
    chk("R1 fifoRstOut", fifoRstOut, 0);

    wr(0, 3, 8'h01);
    chk("R2 enable ep3", enOut, 7'h09);
    chk("R2 readback", rdata, 8'h01);

    wr(0, 3, 8'h03);
    wr(0, 3, 8'h01);
    chk("R3 stall sticky on write 0", stallOut[3], 1);
    chk("R3 readback", rdata, 8'h03);

    setup(5);
    chk("R4 other endpoint setup", stallOut[3], 1);
    setup(3);
    chk("R4 setup clears", stallOut[3], 0);
    wr(0, 3, 8'h03);
    setupRcvd = 1; setupEp = 3;
    wr(0, 3, 8'h03);
    chk("R4 setup beats set", stallOut[3], 0);

    wr(0, 3, 8'h03);
    wr(0, 3, 8'h07);
    chk("R5 clear beats set", stallOut[3], 0);
    chk("R5 strobe reads 0", rdata, 8'h01);

    xfer(3);
    chk("R6 toggle flips", toggleOut[3], 1);
    chk("R6 toggle readback", rdata, 8'h11);
    xfer(4);
    chk("R6 disabled ignores", toggleOut[4], 0);

    xfer(3);
    xferDone = 1; xferEp = 3;
    wr(0, 3, 8'h09);
    chk("R7 reset beats flip", toggleOut[3], 0);
    chk("R7 strobe reads 0", rdata, 8'h01);
    wr(0, 3, 8'h11);
    chk("R6 bit4 write ignored", toggleOut[3], 0);

    wr(1, 0, 8'hFF);
    chk("R9 fifo set", fifoRstOut, 7'h7F);
    chk("R10 fifo reserved bit", rdata, 8'h7F);
    wr(1, 0, 8'h05);
    chk("R9 fifo clear", fifoRstOut, 7'h05);

    wr(0, 3, 8'h03);
    xfer(3);
    busReset = 1;
    wr(0, 1, 8'h01);
    chk("R8 enables", enOut, 7'h01);
    chk("R8 stall", stallOut, 0);
    chk("R8 toggle", toggleOut, 0);
    chk("R8 fifo kept", fifoRstOut, 7'h05);

    wr(0, 7, 8'h03);
    chk("R10 out of range write", enOut, 7'h01);
    chk("R10 out of range read", rdata, 0);
    checkAll();

    for (int i = 0; i < 3000; i++) begin
      regWe = ($urandom % 3) == 0;
      regAddr = ($urandom % 4) == 0;
      epSel = EPW'($urandom);
      wdata = DW'($urandom);
      setupRcvd = ($urandom % 8) == 0;
      setupEp = EPW'($urandom);
      xferDone = ($urandom % 3) == 0;
      xferEp = EPW'($urandom);
      busReset = ($urandom % 64) == 0;
      step();
      checkAll();
    end
    summary();
  end
endmodule